// File: doc/BRIEF.md
# Serial-Programmed Clock Output Enable Controller

This block gates an 18-way clock fan-out. Each output copies a reference clock when its enable bit is set and sits at logic low when the bit is cleared. A global output-enable pin overrides everything. When that pin is low, every output is released to high impedance. The port `clk_drive` carries this as a per-output drive enable, and the pad ring builds the tri-state from it.

The enable bits are loaded over a write-only two-wire serial bus. The block acts as a slave at the fixed 7-bit address 1101001. The system clock oversamples SCL and SDA, and the block detects start and stop conditions itself. After a matching write address, the payload bytes fill three enable registers in order. Each new start condition rewinds the byte counter to the first register.

A new enable value reaches an output only on a falling edge of the reference clock. Because of this, a change never clips or stretches a clock pulse.

Top module: `clk_fanout_en_ctrl`

## Requirements
- R1: After reset every enable bit is 1, so each output follows `ref_clk` and `clk_drive` follows `oe_in`.
- R2: The slave acknowledges the address byte 1101001 followed by write bit 0 by pulling SDA low (`sda_pull`=1) during the ninth SCL pulse, and it acknowledges every payload byte of that transfer in the same way.
- R3: For any other address, or for the read bit set to 1, the slave does not acknowledge, and the bytes that follow leave the enables unchanged.
- R4: Payload bytes are shifted in most significant bit first. In the first payload byte, bit n sets the enable of output n (n = 0..7), and 1 means active.
- R5: In the second payload byte, bit n sets the enable of output 8+n.
- R6: In the third payload byte, bit 7 sets output 17 and bit 6 sets output 16. Bits 5..0 have no effect.
- R7: Payload bytes after the third are acknowledged and have no effect.
- R8: An output whose enable bit is 0 is held low while `oe_in` is high.
- R9: While `oe_in` is low, every bit of `clk_drive` is 0 whatever the enables hold. When `oe_in` returns high, the outputs resume their programmed state.
- R10: An output only rises with a rising `ref_clk` and only falls with a falling `ref_clk`. Every high pulse it emits lasts a full high phase of `ref_clk`.
- R11: A repeated start followed by a matching address sends the next payload byte to the first register again.
- R12: After a stop condition, SCL pulses that arrive without a new start are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock to be fanned out |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line (as seen on the wire) |
| oe_in | input | 1 | Global output enable; low releases all outputs |
| sda_pull | output | 1 | 1 pulls SDA low for an acknowledge |
| clk_out | output | NUM_OUT | Gated clock value per output |
| clk_drive | output | NUM_OUT | Per-output pad drive enable (0 = high impedance) |

## Verification
The bench keeps `NUM_OUT` at 18 and the address at 1101001. It raises `SYNC_STAGES` to 3, which lengthens the delay between a bus edge and its detection. This shows that acknowledge timing and start/stop detection still work with an eight-system-clock half period on SCL. Eighteen outputs bring into reach the partial third register, whose two live bits sit at the top of the byte next to six dead bits. The deeper synchronizer also tests the rule that SDA only moves while SCL is low.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_ADDR,
    SL_AACK,
    SL_DATA,
    SL_DACK
  } slave_state_t;

  // number of payload registers needed for n outputs
  function automatic int reg_count(int n);
    return n / 8 + ((n % 8) != 0 ? 1 : 0);
  endfunction

  // register that holds the enable of output idx
  function automatic int reg_of(int idx, int n);
    return (idx < (n / 8) * 8) ? idx / 8 : n / 8;
  endfunction

  // bit inside that register; a partial last register uses its top bits
  function automatic int bit_of(int idx, int n);
    return (idx < (n / 8) * 8) ? idx % 8 : idx - (n / 8) * 8 + 8 - (n % 8);
  endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic level_d
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain   <= '1;
      level_d <= 1'b1;
    end else begin
      chain   <= {chain[STAGES-2:0], din};
      level_d <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import clk_fanout_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter int         NUM_BYTES   = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         IDXW        = $clog2(NUM_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_pull,
  output logic            wr_stb,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data
);
  logic scl_s, scl_p, sda_s, sda_p;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_in), .level(scl_s), .level_d(scl_p));
  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_in), .level(sda_s), .level_d(sda_p));

  // named bus events
  logic scl_rise, scl_fall, start_det, stop_det, addr_hit, byte_done;
  slave_state_t     state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [IDXW-1:0]  byte_idx;

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign addr_hit  = (shreg[7:1] == DEV_ADDR) && !shreg[0];
  assign byte_done = (bitcnt == 4'd8);

  assign wr_stb  = scl_fall && (state == SL_DATA) && byte_done;
  assign wr_idx  = byte_idx;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SL_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= SL_ADDR;
      bitcnt   <= '0;
      byte_idx <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= SL_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        SL_ADDR, SL_DATA: begin
          if (scl_rise && !byte_done) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && byte_done) begin
            if (state == SL_DATA) begin
              state    <= SL_DACK;
              sda_pull <= 1'b1;
              if (byte_idx != IDXW'(NUM_BYTES)) byte_idx <= byte_idx + IDXW'(1);
            end else if (addr_hit) begin
              state    <= SL_AACK;
              sda_pull <= 1'b1;
            end else begin
              state <= SL_IDLE;
            end
          end
        end
        SL_AACK, SL_DACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= SL_DATA;
            bitcnt   <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // R2
  ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
  // R3
  no_ack_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && state == SL_ADDR && byte_done && !addr_hit && !start_det && !stop_det)
      |=> !sda_pull);
  // R12
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

// File: rtl/enable_bank.sv
module enable_bank
  import clk_fanout_pkg::*;
#(
  parameter int NUM_OUT   = 18,
  parameter int NUM_BYTES = 3,
  parameter int IDXW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [7:0]         wr_data,
  output logic [NUM_OUT-1:0] en
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    localparam int REG = reg_of(i, NUM_OUT);
    localparam int BIT = bit_of(i, NUM_OUT);
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bit_q <= 1'b1;
      else if (wr_stb && wr_idx == IDXW'(REG))     bit_q <= wr_data[BIT];
    end
    assign en[i] = bit_q;
  end

  // R4
  en_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en) |-> $past(wr_stb));
  // R7
  extra_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && int'(wr_idx) >= NUM_BYTES) |=> $stable(en));
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en,
  output logic gated
);
  logic en_q;

  // enable is taken only at a falling reference edge, while ref_clk is low
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en;
  end

  assign gated = ref_clk & en_q;
endmodule

// File: rtl/clk_fanout_en_ctrl.sv
module clk_fanout_en_ctrl
  import clk_fanout_pkg::*;
#(
  parameter int         NUM_OUT     = 18,
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               oe_in,
  output logic               sda_pull,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_drive
);
  localparam int NUM_BYTES = reg_count(NUM_OUT);
  localparam int IDXW      = $clog2(NUM_BYTES + 1);

  logic               wr_stb;
  logic [IDXW-1:0]    wr_idx;
  logic [7:0]         wr_data;
  logic [NUM_OUT-1:0] en;

  cfg_serial_slave #(
    .DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES),
    .SYNC_STAGES(SYNC_STAGES), .IDXW(IDXW)
  ) u_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_pull(sda_pull), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data));

  enable_bank #(.NUM_OUT(NUM_OUT), .NUM_BYTES(NUM_BYTES), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .en(en));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    clk_gate_cell u_gate (
      .ref_clk(ref_clk), .rst_n(rst_n), .en(en[i]), .gated(clk_out[i]));
  end

  assign clk_drive = {NUM_OUT{oe_in}};

  // R10
  out_rise_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clk_out & ~$past(clk_out))) |-> $rose(ref_clk));
  // R10
  out_fall_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~clk_out & $past(clk_out))) |-> $fell(ref_clk));
endmodule

// File: tb/sim_clk_fanout_en_ctrl.sv
module sim_clk_fanout_en_ctrl;
  localparam int NO = 18;
  localparam int HP = 8;
  localparam logic [6:0] ADDR = 7'b1101001;

  logic clk = 0, rst_n = 0, ref_clk = 0, scl = 1, sda_drv = 1, oe = 1;
  bit   ref_run = 0, mon_on = 0, done = 0;
  wire  sda_pull;
  wire [NO-1:0] clk_out, clk_drive;
  wire  sda_bus = sda_drv & ~sda_pull;

  int checks = 0, errors = 0, ref_cnt = 0;
  logic [NO-1:0] exp_en;
  logic [7:0] pay [8];
  int hi_cnt [NO];

  clk_fanout_en_ctrl #(.NUM_OUT(NO), .DEV_ADDR(ADDR), .SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .scl_in(scl), .sda_in(sda_bus),
    .oe_in(oe), .sda_pull(sda_pull), .clk_out(clk_out), .clk_drive(clk_drive));

  always #10 clk = ~clk;

  always @(negedge clk) if (ref_run) begin
    ref_cnt++;
    if (ref_cnt == 4) begin ref_cnt = 0; ref_clk = ~ref_clk; end
  end

  // R10: each emitted pulse must span the whole high phase (4 samples)
  always @(posedge clk) if (mon_on) begin
    for (int i = 0; i < NO; i++) begin
      if (clk_out[i]) hi_cnt[i]++;
      else if (hi_cnt[i] != 0) begin
        checks++;
        if (hi_cnt[i] != 4) begin
          errors++;
          $display("FAIL R10 pulse width out%0d act=%0d exp=4", i, hi_cnt[i]);
        end
        hi_cnt[i] = 0;
      end
    end
  end

  function automatic logic [NO-1:0] model_put(logic [NO-1:0] cur, int idx, logic [7:0] d);
    logic [NO-1:0] r = cur;
    case (idx)
      0: r[7:0]  = d;
      1: r[15:8] = d;
      2: begin r[17] = d[7]; r[16] = d[6]; end
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_drv = 1; hold(HP); scl = 1; hold(HP); sda_drv = 0; hold(HP); scl = 0; hold(2);
  endtask

  task automatic bus_stop();
    sda_drv = 0; hold(HP); scl = 1; hold(HP); sda_drv = 1; hold(HP);
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hold(HP); scl = 1; hold(HP); scl = 0; hold(2);
    end
    sda_drv = 1; hold(HP); scl = 1; hold(HP / 2);
    ack = !sda_bus;
    hold(HP / 2); scl = 0; hold(HP);
  endtask

  task automatic xfer(input logic [7:0] ab, input int n, input bit do_stop, input string tag);
    logic a;
    bit good = (ab == {ADDR, 1'b0});
    bus_start();
    bus_byte(ab, a);
    chk({tag, " R2 addr ack"}, 32'(a), 32'(good));
    for (int k = 0; k < n; k++) begin
      bus_byte(pay[k], a);
      chk({tag, " data ack"}, 32'(a), 32'(good));
      if (good) exp_en = model_put(exp_en, k, pay[k]);
    end
    if (do_stop) bus_stop();
  endtask

  task automatic check_outs(string tag);
    @(posedge ref_clk); repeat (2) @(posedge clk);
    chk({tag, " high phase"}, 32'(clk_out), 32'(exp_en));
    chk({tag, " R9 drive"}, 32'(clk_drive), 32'({NO{oe}}));
    @(negedge ref_clk); repeat (2) @(posedge clk);
    chk({tag, " R8 low phase"}, 32'(clk_out), 32'(0));
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=timeout exp=finished");
      finish_up();
    end
  end

  initial begin
    logic a;
    void'($urandom(32'd7321));
    for (int i = 0; i < NO; i++) hi_cnt[i] = 0;
    ref_run = 1;
    hold(6); rst_n = 1; exp_en = '1; hold(4);
    @(negedge ref_clk); mon_on = 1;

    // R1 reset state
    chk("R1 no ack at reset", 32'(sda_pull), 32'(0));
    check_outs("R1");

    // R4 first register, asymmetric pattern catches bit reversal; R8 low outputs
    pay[0] = 8'hA5; xfer({ADDR, 1'b0}, 1, 1, "R4");
    check_outs("R4 R8");

    // R5 second register
    pay[0] = 8'hFF; pay[1] = 8'h3C; xfer({ADDR, 1'b0}, 2, 1, "R5");
    check_outs("R5");

    // R6 third register, dead bits set to 1
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7F; xfer({ADDR, 1'b0}, 3, 1, "R6");
    check_outs("R6 bit6");
    pay[2] = 8'h80; xfer({ADDR, 1'b0}, 3, 1, "R6");
    check_outs("R6 bit7");

    // R7 bytes beyond the third
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'hC0; pay[3] = 8'h00; pay[4] = 8'h00;
    xfer({ADDR, 1'b0}, 5, 1, "R7");
    check_outs("R7");

    // R3 wrong address and read request
    pay[0] = 8'h00; xfer({7'b1101000, 1'b0}, 1, 1, "R3 wrong addr");
    check_outs("R3");
    xfer({ADDR, 1'b1}, 1, 1, "R3 read");
    check_outs("R3");

    // R9 global enable override
    pay[0] = 8'h5A; xfer({ADDR, 1'b0}, 1, 1, "R9");
    oe = 0; check_outs("R9 off");
    oe = 1; check_outs("R9 on");

    // R11 repeated start rewinds to first register
    pay[0] = 8'h0F; xfer({ADDR, 1'b0}, 1, 0, "R11");
    pay[0] = 8'hF0; xfer({ADDR, 1'b0}, 1, 1, "R11");
    check_outs("R11");

    // R12 clocking without start after stop
    scl = 0; hold(HP);
    bus_byte({ADDR, 1'b0}, a); chk("R12 no ack", 32'(a), 32'(0));
    bus_byte(8'h00, a);        chk("R12 no ack", 32'(a), 32'(0));
    scl = 1; hold(HP);
    check_outs("R12");

    // random traffic
    for (int t = 0; t < 24; t++) begin
      int kind = int'($urandom % 8);
      int n = 1 + int'($urandom % 5);
      logic [7:0] ab;
      if (kind == 0)      ab = {ADDR ^ 7'(1 << ($urandom % 7)), 1'b0};
      else if (kind == 1) ab = {ADDR, 1'b1};
      else                ab = {ADDR, 1'b0};
      for (int k = 0; k < n; k++) pay[k] = 8'($urandom);
      if ($urandom % 6 == 0) oe = ~oe;
      xfer(ab, n, 1, "R4 R5 R6 random");
      check_outs("R3 R7 R9 random");
    end
    oe = 1;
    check_outs("R9 final");

    done = 1;
    finish_up();
  end
endmodule